// File: doc/BRIEF.md
# Parallel All-Pairs Maximum Finder

This block picks the largest of N unsigned W-bit numbers and reports both that value and the position it came from. Every pair of inputs is compared at the same time, so each input-to-output path crosses exactly one magnitude comparator. A winner vector is formed from the results of those comparisons. The value and the index are then both taken from that vector, side by side, through shallow AND-OR selection.

The inputs arrive on one flat packed bus. Element i occupies bits `[W*i +: W]`. A parameter chooses whether the result leaves the block straight from the selection logic or passes through one register stage first. The register stage has a synchronous, active-high reset. N and W are fixed at elaboration time.

Top module: `maxfind_allpairs`

## Requirements
- R1: `max_val` equals the largest element of `data_in`, where element i is `data_in[W*i +: W]`.
- R2: `max_idx` is the binary position i of the element reported in `max_val`. It is IW = max(1, ceil(log2 N)) bits wide.
- R3: When several elements share the largest value, `max_idx` names the lowest of their positions.
- R4: Elements are compared as unsigned numbers, so a value with its top bit set beats any value with its top bit clear.
- R5: With `REG_OUT` = 1, the result for the inputs present at a rising clock edge appears on the outputs just after that edge and holds until the next edge.
- R6: With `REG_OUT` = 1, a high `rst` at a rising edge clears both `max_val` and `max_idx` to zero. This happens regardless of `data_in`.
- R7: With N = 1, `max_val` equals element 0 and `max_idx` is 0.
- R8: With `REG_OUT` = 0, the outputs follow `data_in` with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| data_in | input | N*W | Packed input elements, element i at bits [W*i +: W] |
| max_val | output | W | Largest element |
| max_idx | output | IW | Position of the largest element, lowest position on a tie |

## Verification
The hardest case to reach from the ports is a tie for the largest value spread across several positions, including the highest position. In that case every row but one of the comparison matrix must lose, and the lowest position must still win. Random vectors almost never produce such ties. The stimulus therefore builds them on purpose: all elements equal, duplicates of the maximum placed at the first and last positions, and random vectors whose range is squeezed into a few values so that repeats are common.

// File: rtl/maxfind_pkg.sv
package maxfind_pkg;

    // Width of an index able to name N positions; never below one bit.
    function automatic int idx_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/mf_cmp_matrix.sv
// All-pairs comparison matrix: bit (i*N + j) is set when element i
// beats element j. One comparator per unordered pair, mirrored by inversion.
module mf_cmp_matrix #(
    parameter int N = 8,
    parameter int W = 8
) (
    input  logic [N*W-1:0] data_in,
    output logic [N*N-1:0] beats
);
    for (genvar i = 0; i < N; i++) begin : g_row
        assign beats[i*N + i] = 1'b1;
        for (genvar j = i + 1; j < N; j++) begin : g_col
            logic ge_ij;
            // lower index wins on equality
            assign ge_ij            = data_in[W*i +: W] >= data_in[W*j +: W];
            assign beats[i*N + j]   = ge_ij;
            assign beats[j*N + i]   = ~ge_ij;
        end
    end
endmodule

// File: rtl/mf_winner.sv
// A row that beats every other element marks the winner.
module mf_winner #(
    parameter int N = 8
) (
    input  logic [N*N-1:0] beats,
    output logic [N-1:0]   win
);
    for (genvar i = 0; i < N; i++) begin : g_row
        assign win[i] = &beats[i*N +: N];
    end
endmodule

// File: rtl/mf_select.sv
// Value and index are chosen side by side from the one-hot winner vector.
module mf_select #(
    parameter int N  = 8,
    parameter int W  = 8,
    parameter int IW = 3
) (
    input  logic [N*W-1:0] data_in,
    input  logic [N-1:0]   win,
    output logic [W-1:0]   sel_val,
    output logic [IW-1:0]  sel_idx
);
    always_comb begin
        sel_val = '0;
        sel_idx = '0;
        for (int i = 0; i < N; i++) begin
            sel_val = sel_val | ({W{win[i]}} & data_in[W*i +: W]);
            sel_idx = sel_idx | ({IW{win[i]}} & IW'(i));
        end
    end
endmodule

// File: rtl/maxfind_allpairs.sv
module maxfind_allpairs
    import maxfind_pkg::*;
#(
    parameter int    N       = 8,
    parameter int    W       = 8,
    parameter bit    REG_OUT = 1'b1,
    localparam int   IW      = idx_bits(N)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [N*W-1:0] data_in,
    output logic [W-1:0]   max_val,
    output logic [IW-1:0]  max_idx
);
    typedef struct packed {
        logic [W-1:0]  val;
        logic [IW-1:0] idx;
    } result_t;

    logic [N*N-1:0] beats;
    logic [N-1:0]   win;
    logic [W-1:0]   sel_val;
    logic [IW-1:0]  sel_idx;
    result_t        res_d;
    result_t        res_q;

    mf_cmp_matrix #(.N(N), .W(W)) u_matrix (
        .data_in (data_in),
        .beats   (beats)
    );

    mf_winner #(.N(N)) u_winner (
        .beats (beats),
        .win   (win)
    );

    mf_select #(.N(N), .W(W), .IW(IW)) u_select (
        .data_in (data_in),
        .win     (win),
        .sel_val (sel_val),
        .sel_idx (sel_idx)
    );

    always_comb begin
        res_d.val = sel_val;
        res_d.idx = sel_idx;
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) res_q <= '0;
            else     res_q <= res_d;
        end

        // R5: registered result is the previous cycle's selection
        assert_reg_latency_R5: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> res_q == $past(res_d));
        // R6: a reset edge leaves zeros on both outputs
        assert_reset_clear_R6: assert property (@(posedge clk)
            $past(rst) === 1'b1 |-> res_q == '0);
    end else begin : g_comb
        assign res_q = res_d;
    end

    assign max_val = res_q.val;
    assign max_idx = res_q.idx;

    // R3: exactly one row of the matrix wins
    assert_onehot_win_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot(win));
    // R2: selected index points at the selected value
    assert_idx_matches_R2: assert property (@(posedge clk) disable iff (rst)
        data_in[W*sel_idx +: W] == sel_val);

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R1: no element exceeds the chosen value
        assert_no_larger_R1: assert property (@(posedge clk) disable iff (rst)
            data_in[W*i +: W] <= sel_val);
        // R3: elements before the winner are strictly smaller
        assert_lowest_tie_R3: assert property (@(posedge clk) disable iff (rst)
            (IW'(i) < sel_idx) |-> data_in[W*i +: W] < sel_val);
    end
endmodule

// File: tb/maxfind_allpairs_bench.sv
module maxfind_allpairs_bench;
    localparam int N  = 8;
    localparam int W  = 8;
    localparam int IW = 3;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [N*W-1:0] data_in = '0;
    logic [W-1:0]   max_val;
    logic [IW-1:0]  max_idx;

    logic [W-1:0]   one_in = '0;
    logic [W-1:0]   one_val;
    logic [0:0]     one_idx;

    int checks = 0;
    int errors = 0;
    logic [31:0] seed = 32'h1234_abcd;

    always #5 clk = ~clk;

    maxfind_allpairs #(.N(N), .W(W), .REG_OUT(1'b1)) u_maxfind_allpairs (
        .clk(clk), .rst(rst), .data_in(data_in),
        .max_val(max_val), .max_idx(max_idx)
    );

    maxfind_allpairs #(.N(1), .W(W), .REG_OUT(1'b0)) u_single (
        .clk(clk), .rst(rst), .data_in(one_in),
        .max_val(one_val), .max_idx(one_idx)
    );

    function automatic logic [31:0] next_rand(input logic [31:0] s);
        logic [31:0] x = s;
        x ^= x << 13; x ^= x >> 17; x ^= x << 5;
        return x;
    endfunction

    // linear scan, strict compare keeps the lowest index on ties
    task automatic ref_max(input logic [N*W-1:0] d,
                           output logic [W-1:0] v, output logic [IW-1:0] ix);
        v = d[W-1:0]; ix = '0;
        for (int i = 1; i < N; i++)
            if (d[W*i +: W] > v) begin v = d[W*i +: W]; ix = IW'(i); end
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive at a falling edge, sample at the falling edge after capture
    task automatic apply_and_check(input logic [N*W-1:0] d, input string tag);
        logic [W-1:0] ev; logic [IW-1:0] ei;
        data_in = d;
        @(negedge clk);
        ref_max(d, ev, ei);
        check({tag, " value"}, 32'(max_val), 32'(ev));
        check({tag, " index"}, 32'(max_idx), 32'(ei));
    endtask

    task automatic t_reset_state();   // R6
        check("R6 reset value", 32'(max_val), 0);
        check("R6 reset index", 32'(max_idx), 0);
    endtask

    task automatic t_distinct();      // R1 R2
        apply_and_check({8'd3, 8'd9, 8'd1, 8'd77, 8'd5, 8'd2, 8'd8, 8'd4}, "R1 R2 distinct");
        apply_and_check({8'd10, 8'd20, 8'd30, 8'd40, 8'd50, 8'd60, 8'd70, 8'd80}, "R1 R2 ascending-down");
    endtask

    task automatic t_ends();          // R2 first and last positions
        apply_and_check({8'd1, 8'd2, 8'd3, 8'd4, 8'd5, 8'd6, 8'd7, 8'd200}, "R2 first");
        apply_and_check({8'd200, 8'd2, 8'd3, 8'd4, 8'd5, 8'd6, 8'd7, 8'd1}, "R2 last");
        check("R2 last index", 32'(max_idx), 7);
    endtask

    task automatic t_ties();          // R3
        apply_and_check({N{8'h5a}}, "R3 all equal");
        check("R3 all equal index", 32'(max_idx), 0);
        apply_and_check({8'd99, 8'd1, 8'd99, 8'd4, 8'd5, 8'd99, 8'd7, 8'd2}, "R3 tie middle");
        check("R3 tie middle index", 32'(max_idx), 2);
        apply_and_check({8'd250, 8'd1, 8'd2, 8'd3, 8'd4, 8'd5, 8'd6, 8'd250}, "R3 tie first last");
        check("R3 tie first last index", 32'(max_idx), 0);
    endtask

    task automatic t_unsigned();      // R4
        apply_and_check({8'h7f, 8'h7f, 8'h7f, 8'h80, 8'h7f, 8'h00, 8'h7f, 8'h7f}, "R4 unsigned");
        check("R4 top bit wins", 32'(max_val), 32'h80);
        apply_and_check({N{8'hff}} ^ {8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h01}, "R4 all high");
    endtask

    task automatic t_random();        // R1 R2 R3 random, some with narrow range
        for (int n = 0; n < 200; n++) begin
            logic [N*W-1:0] d;
            for (int i = 0; i < N; i++) begin
                seed = next_rand(seed);
                d[W*i +: W] = (n % 2 == 0) ? seed[W-1:0] : W'(seed[1:0]);
            end
            apply_and_check(d, "R1 R3 random");
        end
    endtask

    task automatic t_latency();       // R5
        logic [W-1:0] ev; logic [IW-1:0] ei;
        data_in = {8'd1, 8'd2, 8'd3, 8'd4, 8'd5, 8'd6, 8'd7, 8'd8};
        @(negedge clk);
        ref_max(data_in, ev, ei);
        data_in = {8'd90, 8'd2, 8'd3, 8'd4, 8'd5, 8'd6, 8'd7, 8'd8};
        #2;
        check("R5 holds before edge", 32'(max_val), 32'(ev));
        @(negedge clk);
        check("R5 updates after edge", 32'(max_val), 90);
        check("R5 updates index", 32'(max_idx), 7);
    endtask

    task automatic t_mid_reset();     // R6
        data_in = {8'd1, 8'd2, 8'd3, 8'd4, 8'd5, 8'd6, 8'd7, 8'd8};
        rst = 1'b1;
        @(negedge clk);
        check("R6 reset value", 32'(max_val), 0);
        check("R6 reset index", 32'(max_idx), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R6 release", 32'(max_val), 8);
    endtask

    task automatic t_single();        // R7 R8
        one_in = 8'hc3;
        #1;
        check("R7 R8 single value", 32'(one_val), 32'hc3);
        check("R7 single index", 32'(one_idx), 0);
        one_in = 8'h00;
        #1;
        check("R8 follows input", 32'(one_val), 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        t_reset_state();
        rst = 1'b0;
        t_distinct();
        t_ends();
        t_ties();
        t_unsigned();
        t_random();
        t_latency();
        t_mid_reset();
        t_single();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule